// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the memory address for one load/store operand and the value to write back into the base register. It supports four addressing modes: register direct, register indirect, indirect with post-increment and indirect with pre-decrement. The caller presents three inputs: a 2-bit mode code, a 2-bit operand size code and the current 32-bit contents of the base register. The step used by the updating modes depends on the operand size: 1 for a byte, 2 for a halfword, 4 for a 32-bit word.

Address formation is combinational. A single registered output stage with a valid/ready handshake then presents all the results together: the effective address, the register-operand flag, the write-back enable, the new register value and an illegal-size flag. The surrounding pipeline drives `accessOk` with the request to say that the access completed without fault. Only then may the base register be updated.

Top module: `opnd_ea_gen`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: Mode 00 (register direct) gives `opIsReg`=1, `eaAddr`=0, `wbEn`=0 and `wbVal`=`baseVal`.
- R3: Mode 01 (register indirect) gives `eaAddr`=`baseVal`, `opIsReg`=0, `wbEn`=0 and `wbVal`=`baseVal`.
- R4: Mode 10 (post-increment) gives `eaAddr`=`baseVal`, which is the old value, and `wbVal`=`baseVal`+step.
- R5: Mode 11 (pre-decrement) gives `wbVal`=`baseVal`-step, and `eaAddr` equals that same reduced value.
- R6: The step is 1 for size 00 (byte), 2 for size 01 (halfword) and 4 for size 10 (word).
- R7: Increment and decrement wrap modulo 2^32. For example, 0xFFFFFFFF+1 gives 0, and 0-1 gives 0xFFFFFFFF.
- R8: `wbEn` is 1 only when all of these hold: the mode is 10 or 11, `accessOk` was 1 on the accepted request, and the size code is legal.
- R9: Size code 11 sets `sizeErr`=1, forces `wbEn`=0 and uses a step of 0, so that `eaAddr` and `wbVal` equal `baseVal` in the indirect modes.
- R10: `inReady` = !`outValid` || `outReady`. While `outValid`=1 and `outReady`=0, every output holds its value and a new request is not taken.
- R11: A request accepted on a clock edge appears on the outputs, with `outValid`=1, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| modeSel | input | 2 | Addressing mode code |
| sizeSel | input | 2 | Operand size code |
| baseVal | input | 32 | Current base register contents |
| accessOk | input | 1 | Access completed without fault |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| eaAddr | output | 32 | Effective address (0 when the operand is the register) |
| opIsReg | output | 1 | Operand is the register itself |
| wbEn | output | 1 | Write `wbVal` into the base register |
| wbVal | output | 32 | Updated register value |
| sizeErr | output | 1 | Illegal size code seen |

## Verification
The two updating modes are driven with the same base value at all three sizes. This distinguishes an adder that issues the old value from one that issues the new value, and it exposes a mis-scaled step. Bases of 0, 0xFFFFFFFF and 0xFFFFFFFE check wraparound in both directions. A cleared `accessOk` and the illegal size code check gating that is independent of the address. A stalled consumer shows whether the output stage holds its value or is overwritten.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_INDIR  = 2'b01,
    MODE_POSTINC = 2'b10,
    MODE_PREDEC = 2'b11
  } eaMode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } eaSize_e;

  localparam int STEP_W = 3;

  typedef struct packed {
    logic              regOperand;
    logic              useStep;
    logic              subtract;
    logic              addrFromNew;
    logic              wbAllowed;
    logic              sizeBad;
    logic [STEP_W-1:0] stepSel;
  } eaStrobe_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic [1:0] sizeSel,
  input  logic       accessOk,
  output eaStrobe_t  strb
);
  logic isUpdate;

  always_comb begin
    strb = '0;
    unique case (sizeSel)
      SZ_BYTE: strb.stepSel = 3'b001;
      SZ_HALF: strb.stepSel = 3'b010;
      SZ_WORD: strb.stepSel = 3'b100;
      default: begin
        strb.stepSel = 3'b000;
        strb.sizeBad = 1'b1;
      end
    endcase
    unique case (modeSel)
      MODE_DIRECT: strb.regOperand = 1'b1;
      MODE_INDIR:  strb.useStep = 1'b0;
      MODE_POSTINC: strb.useStep = 1'b1;
      default: begin
        strb.useStep     = 1'b1;
        strb.subtract    = 1'b1;
        strb.addrFromNew = 1'b1;
      end
    endcase
    isUpdate = (modeSel == MODE_POSTINC) || (modeSel == MODE_PREDEC);
    strb.wbAllowed = isUpdate && accessOk && !strb.sizeBad;
  end

  // R8
  wbgate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wbAllowed |-> (modeSel[1] && accessOk && sizeSel != 2'b11));

  // R9
  badsize_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeSel == 2'b11) |-> (strb.sizeBad && strb.stepSel == '0 && !strb.wbAllowed));

  // R6
  stepsel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeSel != 2'b11) |-> ($countones(strb.stepSel) == 1));
endmodule

// File: rtl/ea_dpath.sv
module ea_dpath
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  eaStrobe_t         strb,
  input  logic [ADDR_W-1:0] baseVal,
  output logic [ADDR_W-1:0] eaNext,
  output logic [ADDR_W-1:0] wbValNext
);
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] adjusted;

  always_comb begin
    stepVal   = ADDR_W'(strb.stepSel);
    adjusted  = strb.subtract ? (baseVal - stepVal) : (baseVal + stepVal);
    wbValNext = strb.useStep ? adjusted : baseVal;
    if (strb.regOperand)
      eaNext = '0;
    else if (strb.addrFromNew)
      eaNext = adjusted;
    else
      eaNext = baseVal;
  end
endmodule

// File: rtl/ea_outreg.sv
module ea_outreg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              outReady,
  input  logic [ADDR_W-1:0] eaD,
  input  logic              isRegD,
  input  logic              wbEnD,
  input  logic [ADDR_W-1:0] wbValD,
  input  logic              errD,
  output logic              outValid,
  output logic [ADDR_W-1:0] eaQ,
  output logic              isRegQ,
  output logic              wbEnQ,
  output logic [ADDR_W-1:0] wbValQ,
  output logic              errQ
);
  logic load;

  assign inReady = !outValid || outReady;
  assign load    = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      eaQ      <= '0;
      isRegQ   <= 1'b0;
      wbEnQ    <= 1'b0;
      wbValQ   <= '0;
      errQ     <= 1'b0;
    end else if (load) begin
      outValid <= 1'b1;
      eaQ      <= eaD;
      isRegQ   <= isRegD;
      wbEnQ    <= wbEnD;
      wbValQ   <= wbValD;
      errQ     <= errD;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(eaQ) && $stable(wbValQ)
                                 && $stable(wbEnQ) && $stable(isRegQ) && $stable(errQ)));

  // R11
  load_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R10
  drop_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outReady));
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        sizeSel,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic              accessOk,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] eaAddr,
  output logic              opIsReg,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbVal,
  output logic              sizeErr
);
  eaStrobe_t         strb;
  logic [ADDR_W-1:0] eaNext;
  logic [ADDR_W-1:0] wbValNext;

  ea_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sizeSel(sizeSel),
    .accessOk(accessOk), .strb(strb)
  );

  ea_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .strb(strb), .baseVal(baseVal), .eaNext(eaNext), .wbValNext(wbValNext)
  );

  ea_outreg #(.ADDR_W(ADDR_W)) uOut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .eaD(eaNext), .isRegD(strb.regOperand),
    .wbEnD(strb.wbAllowed), .wbValD(wbValNext), .errD(strb.sizeBad),
    .outValid(outValid), .eaQ(eaAddr), .isRegQ(opIsReg), .wbEnQ(wbEn),
    .wbValQ(wbVal), .errQ(sizeErr)
  );
endmodule

// File: tb/opnd_ea_gen_test.sv
module opnd_ea_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  modeSel = 2'b00;
  logic [1:0]  sizeSel = 2'b00;
  logic [31:0] baseVal = '0;
  logic        accessOk = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] eaAddr;
  logic        opIsReg;
  logic        wbEn;
  logic [31:0] wbVal;
  logic        sizeErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  opnd_ea_gen uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .modeSel(modeSel), .sizeSel(sizeSel), .baseVal(baseVal), .accessOk(accessOk),
    .outValid(outValid), .outReady(outReady), .eaAddr(eaAddr), .opIsReg(opIsReg),
    .wbEn(wbEn), .wbVal(wbVal), .sizeErr(sizeErr)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stepOf(input logic [1:0] s);
    case (s)
      2'b00: return 32'd1;
      2'b01: return 32'd2;
      2'b10: return 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  task automatic issue(input logic [1:0] m, input logic [1:0] s,
                       input logic [31:0] b, input logic ok);
    @(negedge clk);
    modeSel = m; sizeSel = s; baseVal = b; accessOk = ok; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectOut(input string tag, input logic [31:0] ea, input logic isReg,
                           input logic wbe, input logic [31:0] wbv, input logic err);
    check({tag, " R11 valid"}, 32'(outValid), 32'd1);
    check({tag, " ea"}, eaAddr, ea);
    check({tag, " opIsReg"}, 32'(opIsReg), 32'(isReg));
    check({tag, " wbEn"}, 32'(wbEn), 32'(wbe));
    check({tag, " wbVal"}, wbVal, wbv);
    check({tag, " sizeErr"}, 32'(sizeErr), 32'(err));
  endtask

  task automatic testReset;
    check("R1 outValid", 32'(outValid), 32'd0);
    check("R1 inReady", 32'(inReady), 32'd1);
  endtask

  task automatic testDirect;
    issue(2'b00, 2'b10, 32'h1234_5678, 1'b1);
    expectOut("R2 direct", 32'd0, 1'b1, 1'b0, 32'h1234_5678, 1'b0);
  endtask

  task automatic testIndirect;
    issue(2'b01, 2'b01, 32'h8000_0010, 1'b1);
    expectOut("R3 indirect", 32'h8000_0010, 1'b0, 1'b0, 32'h8000_0010, 1'b0);
  endtask

  task automatic testPostInc;
    for (int s = 0; s < 3; s++) begin
      issue(2'b10, 2'(s), 32'h0000_1000, 1'b1);
      expectOut($sformatf("R4 R6 postinc size%0d", s), 32'h0000_1000, 1'b0, 1'b1,
                32'h0000_1000 + stepOf(2'(s)), 1'b0);
    end
  endtask

  task automatic testPreDec;
    for (int s = 0; s < 3; s++) begin
      issue(2'b11, 2'(s), 32'h0000_1000, 1'b1);
      expectOut($sformatf("R5 R6 predec size%0d", s), 32'h0000_1000 - stepOf(2'(s)),
                1'b0, 1'b1, 32'h0000_1000 - stepOf(2'(s)), 1'b0);
    end
  endtask

  task automatic testWrap;
    for (int s = 0; s < 3; s++) begin
      issue(2'b10, 2'(s), 32'hFFFF_FFFF, 1'b1);
      expectOut($sformatf("R7 postinc wrap size%0d", s), 32'hFFFF_FFFF, 1'b0, 1'b1,
                32'hFFFF_FFFF + stepOf(2'(s)), 1'b0);
      issue(2'b11, 2'(s), 32'h0000_0000, 1'b1);
      expectOut($sformatf("R7 predec wrap size%0d", s), 32'h0 - stepOf(2'(s)),
                1'b0, 1'b1, 32'h0 - stepOf(2'(s)), 1'b0);
    end
    issue(2'b10, 2'b10, 32'hFFFF_FFFE, 1'b1);
    expectOut("R7 postinc word wrap", 32'hFFFF_FFFE, 1'b0, 1'b1, 32'h0000_0002, 1'b0);
  endtask

  task automatic testFault;
    issue(2'b10, 2'b01, 32'h0000_0200, 1'b0);
    expectOut("R8 postinc fault", 32'h0000_0200, 1'b0, 1'b0, 32'h0000_0202, 1'b0);
    issue(2'b11, 2'b10, 32'h0000_0200, 1'b0);
    expectOut("R8 predec fault", 32'h0000_01FC, 1'b0, 1'b0, 32'h0000_01FC, 1'b0);
  endtask

  task automatic testIllegal;
    issue(2'b10, 2'b11, 32'h0000_0400, 1'b1);
    expectOut("R9 postinc bad size", 32'h0000_0400, 1'b0, 1'b0, 32'h0000_0400, 1'b1);
    issue(2'b11, 2'b11, 32'h0000_0400, 1'b1);
    expectOut("R9 predec bad size", 32'h0000_0400, 1'b0, 1'b0, 32'h0000_0400, 1'b1);
  endtask

  task automatic testBackpressure;
    @(negedge clk);
    check("R10 drained", 32'(outValid), 32'd0);
    outReady = 1'b0;
    issue(2'b10, 2'b00, 32'h0000_0050, 1'b1);
    expectOut("R10 first", 32'h0000_0050, 1'b0, 1'b1, 32'h0000_0051, 1'b0);
    modeSel = 2'b11; sizeSel = 2'b10; baseVal = 32'h0000_0900; accessOk = 1'b1;
    inValid = 1'b1;
    check("R10 inReady stalled", 32'(inReady), 32'd0);
    @(negedge clk);
    expectOut("R10 held", 32'h0000_0050, 1'b0, 1'b1, 32'h0000_0051, 1'b0);
    outReady = 1'b1;
    #1;
    check("R10 inReady released", 32'(inReady), 32'd1);
    @(negedge clk);
    inValid = 1'b0;
    expectOut("R10 second", 32'h0000_08FC, 1'b0, 1'b1, 32'h0000_08FC, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirect();
    testIndirect();
    testPostInc();
    testPreDec();
    testWrap();
    testFault();
    testIllegal();
    testBackpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule